// File: doc/BRIEF.md
# Chained SPI Register Read Sequencer

This block is a host-side SPI controller. It reads one configuration register from each of several converters that are wired as a daisy chain and share one chip select. A single start request runs a fixed series of four chained transactions. Each transaction places one 24-bit frame per device in a single chip-select window. Chip select goes high between transactions, so each device acts on the frame it holds at that point.

The four transactions are, in order: a bank-select write, a write that clears the read-enable bit, an address command that loads each device's output register, and an all-ones readout. During the readout every device shifts back its 8-bit register address and then its 16-bit register data. The sequencer stores one word per device. It compares each returned address field with the address requested for that device and raises a per-device error bit on a mismatch.

The chain length, the SCLK half-period and the chip-select gap are parameters. The register numbers of the bank-select and read-enable registers are also parameters. The host supplies one address byte and one bank byte per device, pulses start while ready is high, and collects the results when the valid flag rises.

Top module: `dcrd_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, ready is 1 and res_valid is 0.
- R2: One request produces exactly four chip-select-low windows. Each window carries exactly N_DEV×24 SCLK rising edges, and cs_n stays low for the whole window.
- R3: In the first window, device i receives the frame {BANK_REG, 8'h00, dev_bank[8i+7:8i]}.
- R4: In the second window, every device receives {RDEN_REG, 16'h0000}.
- R5: In the third window, device i receives {8'hFE, 8'h00, dev_addr[8i+7:8i]}.
- R6: In the fourth window, every device receives 24'hFFFFFF.
- R7: Frames are sent most significant bit first, and the frame for the device nearest MISO (index N_DEV-1) is sent first. The word returned by device i appears in res_word[24i+23:24i], with the address in bits [23:16] and the data in bits [15:0].
- R8: SPI mode 0 applies. sclk is 0 whenever cs_n is 1. mosi changes only while sclk is low. MISO is sampled on the rising edge.
- R9: addr_err[i] is 1 exactly when the returned address field of device i differs from the address requested for device i. The flag is valid while res_valid is 1.
- R10: When ready and start are both 1, ready drops in the next cycle. Start is ignored while ready is 0. res_valid rises together with ready at the end of the request, and stays high until the next accepted start. cs_n is never low while ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a chained read; accepted while ready is high |
| dev_addr | input | N_DEV*8 | Register address per device, device i in byte i |
| dev_bank | input | N_DEV*8 | Register bank per device, device i in byte i |
| ready | output | 1 | Sequencer idle and able to accept start |
| res_word | output | N_DEV*24 | Returned address and data per device, device i in word i |
| res_valid | output | 1 | res_word and addr_err hold the last request's result |
| addr_err | output | N_DEV | Per-device returned-address mismatch |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | Shared chip select, active low |
| mosi | output | 1 | Serial data to the first device of the chain |
| miso | input | 1 | Serial data from the last device of the chain |

## Verification
The sensitive coincidence is a new start that arrives in the same cycle the previous result is presented, which is also the cycle ready returns. The bench provokes it by holding start high through a whole request, so the start is ignored while busy and taken again the moment the sequencer goes idle. New addresses are applied just before that edge. The bench then judges whether the first request's results were intact when valid rose, and whether the second request's frames and results use the new addresses. A second coincidence, the final falling SCLK edge against the rise of chip select, is judged by the chained device models: every window must hand each device a complete 24-bit frame.

// File: rtl/dcrd_pkg.sv
package dcrd_pkg;

    localparam int FRAME_W = 24;
    localparam logic [7:0] CMD_READ = 8'hFE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_BANK,
        PH_RDEN,
        PH_ADDR,
        PH_READ
    } seq_phase_e;

    typedef struct packed {
        logic [7:0]  addr;
        logic [15:0] data;
    } rd_word_t;

    function automatic logic [FRAME_W-1:0] mk_frame(
        input seq_phase_e ph,
        input logic [7:0] bank_reg,
        input logic [7:0] rden_reg,
        input logic [7:0] bank,
        input logic [7:0] addr
    );
        logic [FRAME_W-1:0] f;
        case (ph)
            PH_BANK: f = {bank_reg, 8'h00, bank};
            PH_RDEN: f = {rden_reg, 16'h0000};
            PH_ADDR: f = {CMD_READ, 8'h00, addr};
            default: f = {FRAME_W{1'b1}};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/dcrd_sclk_gen.sv
module dcrd_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(HALF_DIV - 1));
    assign rise = run && wrap && !sclk;
    assign fall = run && wrap && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sclk) else $error("sclk not parked"); // R8

endmodule

// File: rtl/dcrd_shift.sv
module dcrd_shift #(
    parameter int W = 72
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         rise,
    input  logic         fall,
    input  logic         miso,
    output logic         msb,
    output logic [W-1:0] vec
);
    logic smp;

    assign msb = vec[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            vec <= '0;
            smp <= 1'b0;
        end else begin
            if (rise) smp <= miso;
            if (load)      vec <= load_val;
            else if (fall) vec <= {vec[W-2:0], smp};
        end
    end

endmodule

// File: rtl/dcrd_frame_mux.sv
module dcrd_frame_mux
    import dcrd_pkg::*;
#(
    parameter int         N_DEV    = 3,
    parameter logic [7:0] BANK_REG = 8'h03,
    parameter logic [7:0] RDEN_REG = 8'h04
) (
    input  seq_phase_e               ph,
    input  logic [N_DEV*8-1:0]       bank_vec,
    input  logic [N_DEV*8-1:0]       addr_vec,
    output logic [N_DEV*FRAME_W-1:0] tx_vec
);
    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        assign tx_vec[g*FRAME_W +: FRAME_W] =
            mk_frame(ph, BANK_REG, RDEN_REG, bank_vec[g*8 +: 8], addr_vec[g*8 +: 8]);
    end

endmodule

// File: rtl/dcrd_seq.sv
module dcrd_seq
    import dcrd_pkg::*;
#(
    parameter int         N_DEV    = 3,
    parameter int         HALF_DIV = 2,
    parameter int         GAP_CYC  = 3,
    parameter logic [7:0] BANK_REG = 8'h03,
    parameter logic [7:0] RDEN_REG = 8'h04
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [N_DEV*8-1:0]       dev_addr,
    input  logic [N_DEV*8-1:0]       dev_bank,
    output logic                     ready,
    output logic [N_DEV*FRAME_W-1:0] res_word,
    output logic                     res_valid,
    output logic [N_DEV-1:0]         addr_err,
    output logic                     sclk,
    output logic                     cs_n,
    input  logic                     miso,
    output logic                     mosi
);
    localparam int TOT = N_DEV * FRAME_W;
    localparam int BW  = $clog2(TOT);
    localparam int GW  = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    seq_state_e          state;
    seq_phase_e          phase;
    logic [BW-1:0]       bitcnt;
    logic [GW-1:0]       gapcnt;
    logic [N_DEV*8-1:0]  addr_q;
    logic [N_DEV*8-1:0]  bank_q;
    logic                run, rise, fall, msb, cs_low, last_bit;
    logic [TOT-1:0]      tx_vec, rx_vec;
    logic [N_DEV-1:0]    err_nxt;

    assign run      = (state == ST_SHIFT);
    assign last_bit = (bitcnt == BW'(TOT - 1));
    assign cs_low   = run || (state == ST_DONE) || (state == ST_GAP && gapcnt == '0);
    assign cs_n     = !cs_low;
    assign mosi     = run && msb;
    assign ready    = (state == ST_IDLE);

    dcrd_sclk_gen #(.HALF_DIV(HALF_DIV)) i_clkgen (
        .clk(clk), .rst(rst), .run(run), .sclk(sclk), .rise(rise), .fall(fall)
    );

    dcrd_frame_mux #(.N_DEV(N_DEV), .BANK_REG(BANK_REG), .RDEN_REG(RDEN_REG)) i_mux (
        .ph(phase), .bank_vec(bank_q), .addr_vec(addr_q), .tx_vec(tx_vec)
    );

    dcrd_shift #(.W(TOT)) i_shift (
        .clk(clk), .rst(rst), .load(state == ST_LOAD), .load_val(tx_vec),
        .rise(rise), .fall(fall), .miso(miso), .msb(msb), .vec(rx_vec)
    );

    always_comb begin
        for (int i = 0; i < N_DEV; i++) begin
            rd_word_t w;
            w = rd_word_t'(rx_vec[i*FRAME_W +: FRAME_W]);
            err_nxt[i] = (w.addr != addr_q[i*8 +: 8]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= PH_BANK;
            bitcnt    <= '0;
            gapcnt    <= '0;
            addr_q    <= '0;
            bank_q    <= '0;
            res_word  <= '0;
            addr_err  <= '0;
            res_valid <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    addr_q    <= dev_addr;
                    bank_q    <= dev_bank;
                    phase     <= PH_BANK;
                    res_valid <= 1'b0;
                    state     <= ST_LOAD;
                end
                ST_LOAD: begin
                    bitcnt <= '0;
                    state  <= ST_SHIFT;
                end
                ST_SHIFT: if (fall) begin
                    if (last_bit) begin
                        gapcnt <= '0;
                        state  <= (phase == PH_READ) ? ST_DONE : ST_GAP;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (gapcnt == GW'(GAP_CYC - 1)) begin
                        phase <= seq_phase_e'(phase + 2'd1);
                        state <= ST_LOAD;
                    end else begin
                        gapcnt <= gapcnt + 1'b1;
                    end
                end
                default: begin
                    res_word  <= rx_vec;
                    addr_err  <= err_nxt;
                    res_valid <= 1'b1;
                    state     <= ST_IDLE;
                end
            endcase
        end
    end

    AST_CS_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk) else $error("sclk active with cs high"); // R8
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && sclk) |-> $stable(mosi)) else $error("mosi moved while sclk high"); // R8
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> !ready) else $error("start not taken"); // R10
    AST_VALID_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ready) else $error("valid while busy"); // R10
    AST_NO_CS_IDLE: assert property (@(posedge clk) disable iff (rst)
        ready |-> cs_n) else $error("cs low while idle"); // R10
    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        bitcnt < BW'(TOT)) else $error("bit counter overflow"); // R2

endmodule

// File: tb/test_dcrd_seq.sv
module test_dcrd_seq;
    localparam int N   = 3;
    localparam int TOT = N * 24;
    localparam logic [7:0] BANK_REG = 8'h03;
    localparam logic [7:0] RDEN_REG = 8'h04;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [N*8-1:0]  dev_addr = '0;
    logic [N*8-1:0]  dev_bank = '0;
    logic            ready, res_valid, sclk, cs_n, mosi, miso;
    logic [N*24-1:0] res_word;
    logic [N-1:0]    addr_err;

    always #4 clk = ~clk;

    dcrd_seq #(.N_DEV(N), .HALF_DIV(2), .GAP_CYC(3), .BANK_REG(BANK_REG), .RDEN_REG(RDEN_REG))
    i_dcrd_seq (
        .clk(clk), .rst(rst), .start(start), .dev_addr(dev_addr), .dev_bank(dev_bank),
        .ready(ready), .res_word(res_word), .res_valid(res_valid), .addr_err(addr_err),
        .sclk(sclk), .cs_n(cs_n), .miso(miso), .mosi(mosi)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp,
                       input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural chain of devices; device 0 sits at mosi, device N-1 drives miso
    logic [23:0] dsr   [N];
    logic        din_s [N];
    logic [7:0]  bank_m[N];
    logic        rden_m[N];
    logic [23:0] logs  [N][4];
    logic [N-1:0] corrupt = '0;
    int bits = 0;
    int txn  = 0;

    initial begin
        for (int i = 0; i < N; i++) begin
            dsr[i] = '0; din_s[i] = 1'b0; bank_m[i] = '0; rden_m[i] = 1'b1;
        end
    end

    assign miso = dsr[N-1][23];

    always @(posedge sclk) if (!cs_n) begin
        for (int i = 0; i < N; i++) din_s[i] = (i == 0) ? mosi : dsr[i-1][23];
        bits++;
    end

    always @(negedge sclk) if (!cs_n) begin
        for (int i = 0; i < N; i++) dsr[i] = {dsr[i][22:0], din_s[i]};
    end

    always @(negedge cs_n) bits = 0;

    always @(posedge cs_n) if (bits > 0) begin
        chk("R2", 80'(bits), 80'(TOT), "rising sclk edges in window");
        for (int i = 0; i < N; i++) begin
            if (txn < 4) logs[i][txn] = dsr[i];
            if (dsr[i][23:16] == BANK_REG)      bank_m[i] = dsr[i][7:0];
            else if (dsr[i][23:16] == RDEN_REG) rden_m[i] = dsr[i][0];
            else if (dsr[i][23:16] == 8'hFE) begin
                logic [7:0] a;
                a = dsr[i][7:0];
                dsr[i] = {a ^ {7'b0, corrupt[i]},
                          rden_m[i] ? 16'h0000 : {4'(i), bank_m[i][3:0], a}};
            end
        end
        txn++;
    end

    // Per-clock protocol comparison
    logic prev_sclk = 1'b0;
    logic prev_mosi = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (cs_n) chk("R8", 80'(sclk), 80'(0), "sclk while cs high");
            if (sclk && prev_sclk) chk("R8", 80'(mosi), 80'(prev_mosi), "mosi while sclk high");
            if (ready) chk("R10", 80'(cs_n), 80'(1), "cs while ready");
            if (res_valid) chk("R10", 80'(ready), 80'(1), "valid implies ready");
        end
        prev_sclk = sclk;
        prev_mosi = mosi;
    end

    task automatic wait_valid();
        int n = 0;
        while (!res_valid && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (!res_valid) chk("R10", 80'(0), 80'(1), "watchdog: result never valid");
    endtask

    task automatic verify(input logic [N*8-1:0] a, input logic [N*8-1:0] b);
        chk("R2", 80'(txn), 80'(4), "chip-select windows");
        for (int i = 0; i < N; i++) begin
            logic [7:0] ai, bi;
            ai = a[i*8 +: 8];
            bi = b[i*8 +: 8];
            chk("R3", 80'(logs[i][0]), 80'({BANK_REG, 8'h00, bi}), $sformatf("bank frame dev %0d", i));
            chk("R4", 80'(logs[i][1]), 80'({RDEN_REG, 16'h0000}), $sformatf("rden frame dev %0d", i));
            chk("R5", 80'(logs[i][2]), 80'({8'hFE, 8'h00, ai}), $sformatf("addr frame dev %0d", i));
            chk("R6", 80'(logs[i][3]), 80'(24'hFFFFFF), $sformatf("read frame dev %0d", i));
            chk("R7", 80'(res_word[i*24 +: 24]),
                80'({ai ^ {7'b0, corrupt[i]}, 4'(i), bi[3:0], ai}), $sformatf("result word dev %0d", i));
            chk("R9", 80'(addr_err[i]), 80'(corrupt[i]), $sformatf("addr error dev %0d", i));
        end
        chk("R10", 80'(ready), 80'(1), "ready with valid");
    endtask

    task automatic run_once(input logic [N*8-1:0] a, input logic [N*8-1:0] b);
        @(negedge clk);
        dev_addr = a; dev_bank = b; start = 1'b1; txn = 0;
        @(negedge clk);
        start = 1'b0;
        chk("R10", 80'(ready), 80'(0), "ready after start");
        chk("R10", 80'(res_valid), 80'(0), "valid cleared by start");
        wait_valid();
        verify(a, b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", 80'(cs_n), 80'(1), "cs_n after reset");
        chk("R1", 80'(sclk), 80'(0), "sclk after reset");
        chk("R1", 80'(mosi), 80'(0), "mosi after reset");
        chk("R1", 80'(ready), 80'(1), "ready after reset");
        chk("R1", 80'(res_valid), 80'(0), "valid after reset");

        run_once(24'h1A_2B_3C, 24'h02_01_00);
        run_once(24'h80_FF_01, 24'h07_05_0A);
        corrupt = 3'b010;
        run_once(24'h44_55_66, 24'h01_01_01);
        corrupt = 3'b000;

        // start held high: ignored while busy, retaken in the cycle valid rises
        @(negedge clk);
        dev_addr = 24'h11_22_33; dev_bank = 24'h03_02_01; start = 1'b1; txn = 0;
        @(negedge clk);
        dev_addr = 24'h99_88_77;
        wait_valid();
        verify(24'h11_22_33, 24'h03_02_01);
        dev_addr = 24'hC0_C1_C2; dev_bank = 24'h04_04_04; txn = 0;
        @(negedge clk);
        start = 1'b0;
        chk("R10", 80'(ready), 80'(0), "start taken in valid cycle");
        chk("R10", 80'(res_valid), 80'(0), "valid dropped on retake");
        wait_valid();
        verify(24'hC0_C1_C2, 24'h04_04_04);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk("R10", 80'(0), 80'(1), "global watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule